// File: doc/BRIEF.md
# Decimal-to-Tuning-Word Serial Loader

This block turns a seven-digit decimal frequency, given in hertz as packed BCD, into the 32-bit frequency tuning word of a direct digital synthesizer clocked at 80 MHz. It then sends that word to the synthesizer chip as a 40-bit serial frame. The block does not multiply. Each decimal digit selects a constant from its own small table, and the seven selected constants are added together. Every table is built at elaboration time. Each entry is the tuning-word contribution of that digit value at that decimal weight, rounded to the nearest integer.

A request arrives on a valid/ready stream. The block can hold one request while a frame is on the wire. The upstream side must keep `req_valid` and `req_digits` steady until the handshake completes. When the one-deep holding slot is full, `req_ready` stays low, and that is the only form of back-pressure. Each frame sends the tuning word least significant bit first, then eight phase/control bits that are all zero. The frame ends with a single-cycle update strobe, which tells the synthesizer to apply the new word.

Top module: `dds_word_loader`

## Requirements
- R1: Digit k sits at `req_digits[4k+3:4k]`, and k=0 is the 1 Hz digit. The word sent is the sum, taken modulo 2^32, of round(d_k * 10^k * 2^32 / 80e6) over k = 0..6. Rounding is done per digit, half up.
- R2: Each transfer is exactly 40 rising edges of `ser_clk`. The first 32 bits carry tuning-word bits 0 through 31 in that order. The last 8 bits are the control/phase bits and are all zero.
- R3: `ser_data` changes only while `ser_clk` is low. It is sampled by the receiver on the rising edge of `ser_clk`. During a transfer, the clock spends a fixed number of system cycles high and the same number low.
- R4: After the falling edge of `ser_clk` for bit 40, `dds_update` pulses high for exactly one system cycle. `ser_clk` is low during that pulse.
- R5: `busy` goes high in the cycle after a request is accepted. It stays high until the update strobe of the last queued request ends, then drops. While `busy` is low, `ser_clk` and `ser_data` are low.
- R6: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A request accepted during a transfer is held, and `req_ready` is low while it waits. The held request starts once the current transfer's strobe has ended.
- R7: After reset, `ser_clk`, `ser_data`, `dds_update` and `busy` are low and `req_ready` is high.
- R8: Every accepted request produces exactly one transfer, and transfers go out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frequency request valid |
| req_ready | output | 1 | Holding slot free; handshake completes when valid is also high |
| req_digits | input | 28 | Seven BCD digits, 1 Hz digit in bits 3:0 |
| busy | output | 1 | A request is held or a frame/strobe is in progress |
| ser_clk | output | 1 | Serial word clock to the synthesizer |
| ser_data | output | 1 | Serial data, valid at the rising edge of ser_clk |
| dds_update | output | 1 | One-cycle frequency-update strobe after the 40th bit |

## Verification
Two things can happen at the same time: a new request is accepted into the holding slot while the shifter is mid-frame or raising its update strobe. The bench provokes this by issuing requests back to back and with random short gaps, so acceptances land on every phase of a running frame, including the strobe cycle. The result is judged at the pins. Frames must arrive in acceptance order, each with the word expected from its own digits. Each must have exactly 40 clock edges and one strobe. `busy` must stay high with no gap until the last queued strobe has ended.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
  localparam int TW_W = 32;

  typedef logic [15:0][TW_W-1:0] digit_tbl_t;

  // Rounded tuning-word contribution of every 4-bit digit value at decimal weight 10^k.
  function automatic digit_tbl_t build_digit_tbl(input int k, input longint unsigned ref_hz);
    digit_tbl_t t;
    logic [63:0] pw;
    logic [63:0] num;
    pw = 64'd1;
    for (int i = 0; i < k; i++) pw = pw * 64'd10;
    for (int d = 0; d < 16; d++) begin
      num  = ((64'(d) * pw) << TW_W) + (ref_hz >> 1);
      t[d] = TW_W'(num / ref_hz);
    end
    return t;
  endfunction
endpackage

// File: rtl/dds_tw_calc.sv
module dds_tw_calc
  import dds_loader_pkg::*;
#(
  parameter int NDIG = 7,
  parameter longint unsigned REF_HZ = 64'd80_000_000
)(
  input  logic [4*NDIG-1:0] digits,
  output logic [TW_W-1:0]   tw
);
  logic [NDIG-1:0][TW_W-1:0] part;

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_dig
      localparam digit_tbl_t TBL = build_digit_tbl(k, REF_HZ);
      assign part[k] = TBL[digits[4*k +: 4]];
    end
  endgenerate

  always_comb begin
    tw = '0;
    for (int k = 0; k < NDIG; k++) tw = tw + part[k];
  end
endmodule

// File: rtl/dds_ser_shift.sv
module dds_ser_shift #(
  parameter int FRAME_W = 40,
  parameter int HALF    = 2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               sclk,
  output logic               sdata,
  output logic               active,
  output logic               done
);
  localparam int PH_W = $clog2(HALF + 1);
  localparam int BC_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sreg;
  logic [PH_W-1:0]    phcnt;
  logic [BC_W-1:0]    bitcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      phcnt  <= '0;
      bitcnt <= '0;
      sclk   <= 1'b0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          sreg   <= word;
          active <= 1'b1;
          sclk   <= 1'b0;
          phcnt  <= '0;
          bitcnt <= '0;
        end
      end else if (phcnt == PH_W'(HALF - 1)) begin
        phcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          sreg <= sreg >> 1;
          if (bitcnt == BC_W'(FRAME_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end else begin
        phcnt <= phcnt + 1'b1;
      end
    end
  end

  assign sdata = sreg[0];
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_loader_pkg::*;
#(
  parameter int NDIG   = 7,
  parameter int CTRL_W = 8,
  parameter int HALF   = 2,
  parameter longint unsigned REF_HZ = 64'd80_000_000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [4*NDIG-1:0] req_digits,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              dds_update
);
  localparam int FRAME_W = TW_W + CTRL_W;

  logic              pend_vld;
  logic [4*NDIG-1:0] pend_dig;
  logic [TW_W-1:0]   tw;
  logic              sh_active, sh_done, upd_q, start;

  assign req_ready = !pend_vld;
  assign start     = pend_vld && !sh_active && !sh_done && !upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_dig <= '0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= sh_done;
      if (req_valid && req_ready) begin
        pend_vld <= 1'b1;
        pend_dig <= req_digits;
      end else if (start) begin
        pend_vld <= 1'b0;
      end
    end
  end

  dds_tw_calc #(.NDIG(NDIG), .REF_HZ(REF_HZ)) u_calc (
    .digits (pend_dig),
    .tw     (tw)
  );

  dds_ser_shift #(.FRAME_W(FRAME_W), .HALF(HALF)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .word   ({{CTRL_W{1'b0}}, tw}),
    .sclk   (ser_clk),
    .sdata  (ser_data),
    .active (sh_active),
    .done   (sh_done)
  );

  assign dds_update = upd_q;
  assign busy       = pend_vld || sh_active || sh_done || upd_q;
endmodule

// File: rtl/dds_loader_chk.sv
module dds_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic ser_clk,
  input logic ser_data,
  input logic dds_update
);
  a_r4_update_single: assert property (@(posedge clk) disable iff (!rst_n)
    dds_update |=> !dds_update);
  a_r4_update_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    dds_update |-> !ser_clk);
  a_r5_busy_covers_update: assert property (@(posedge clk) disable iff (!rst_n)
    dds_update |-> busy);
  a_r5_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_data));
  a_r3_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  a_r6_held_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> busy);
endmodule

bind dds_word_loader dds_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .dds_update (dds_update)
);

// File: tb/tb_dds_word_loader.sv
module tb_dds_word_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [27:0] req_digits = '0;
  logic req_ready, busy, ser_clk, ser_data, dds_update;

  int n_chk = 0, n_bad = 0;
  logic [31:0] expq[$];
  logic [39:0] rx;
  int nbits = 0;
  bit prev_sclk = 0, prev_upd = 0, idle_chk = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_word_loader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_digits(req_digits), .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data),
    .dds_update(dds_update)
  );

  function automatic logic [31:0] tw_ref(input logic [27:0] dg);
    logic [63:0] acc, pw, num;
    acc = 0; pw = 1;
    for (int k = 0; k < 7; k++) begin
      num = ((64'(dg[4*k +: 4]) * pw) << 32) + 64'd40_000_000;
      acc = acc + num / 64'd80_000_000;
      pw  = pw * 64'd10;
    end
    return acc[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Pin monitor, sampled at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (idle_chk) begin
      idle_chk = 0;
      check(busy == (expq.size() != 0), "R5 busy after last strobe", busy, expq.size() != 0);
    end
    if (prev_upd) check(!dds_update, "R4 strobe one cycle", dds_update, 0);
    if (ser_clk && !prev_sclk) begin
      if (nbits < 40) rx[nbits] = ser_data;
      nbits++;
    end
    if (dds_update) begin
      check(!ser_clk, "R4 clock low at strobe", ser_clk, 0);
      check(nbits == 40, "R2 bit count", nbits, 40);
      check(rx[39:32] == 8'h00, "R2 control bits zero", rx[39:32], 0);
      if (expq.size() == 0) check(0, "R8 unexpected transfer", 1, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(rx[31:0] == e, "R1 tuning word", rx[31:0], e);
      end
      check(busy, "R5 busy during strobe", busy, 1);
      nbits = 0;
      idle_chk = 1;
    end
    prev_sclk = ser_clk;
    prev_upd  = dds_update;
  end

  task automatic send(input logic [27:0] dg, input bit hold_check);
    @(negedge clk);
    req_valid  = 1'b1;
    req_digits = dg;
    #1;
    while (!req_ready) begin
      if (hold_check) begin
        check(busy, "R6 held request keeps ready low while busy", busy, 1);
        hold_check = 0;
      end
      @(negedge clk); #1;
    end
    expq.push_back(tw_ref(dg));
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R5 busy after accept", busy, 1);
  endtask

  function automatic logic [27:0] rnd_bcd();
    logic [27:0] d;
    for (int k = 0; k < 7; k++) d[4*k +: 4] = 4'($urandom_range(9));
    return d;
  endfunction

  task automatic drain();
    int t = 0;
    while ((expq.size() != 0 || busy) && t < 20000) begin @(negedge clk); t++; end
    check(expq.size() == 0, "R8 all requests delivered", expq.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(!ser_clk && !ser_data && !dds_update && !busy, "R7 outputs low", {ser_clk, ser_data, dds_update, busy}, 0);
    check(req_ready, "R7 ready high", req_ready, 1);
    // Directed corners (R1)
    send(28'h0000000, 0); drain();
    send(28'h9999999, 0); drain();
    send(28'h0000001, 0); drain();
    send(28'h3500000, 0); drain();
    // Back-to-back: second accepted mid-frame, third waits on a full slot (R6, R8)
    send(28'h7050000, 0);
    send(28'h1234567, 0);
    send(28'h0000010, 1);
    drain();
    // Random stream with short gaps so acceptances hit every frame phase (R1, R6, R8)
    for (int i = 0; i < 30; i++) begin
      send(rnd_bcd(), 0);
      repeat ($urandom_range(0, 180)) @(negedge clk);
    end
    drain();
    repeat (5) @(negedge clk);
    check(!busy && !ser_clk && !ser_data, "R5 quiet when idle", {busy, ser_clk, ser_data}, 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end
endmodule